// File: doc/BRIEF.md
# Symmetric PWM Generator with Edge Delay

This block makes a center-aligned pulse-width waveform. A counter climbs from zero to a programmed period value and then falls back to zero. A compare value marks two points in that sweep: the rising crossing switches an internal raw waveform on, and the falling crossing switches it off. The raw waveform then drives two output channels. Channel A copies the raw waveform, but its rise is held back by a programmable number of clocks. Channel B is the inverse of the raw waveform, and its rise is held back by a second, independent delay. The gaps this creates mean the two channels are never active at once, so they can drive the high and low switches of a half bridge.

The period, compare and both delays are sampled only when the counter is at zero. A sweep that is in progress therefore keeps the settings it started with. Two outputs, the counter value and the sweep direction, let other logic line up with the waveform.

Top module: `pwm_updown_db`

## Requirements
- R1: With period P ≥ 1 the counter runs 0, 1, …, P, P−1, …, 1 and then back to 0. One PWM cycle therefore lasts exactly 2·P clocks, and the counter never goes above P.
- R2: `dir_down` becomes 1 on the clock after the counter shows P while counting upward. It becomes 0 on the clock after the counter shows 0.
- R3: With compare C where 1 ≤ C < P, the raw waveform is high for 2·(P−C) clocks per cycle. Channel A is high for max(0, 2·(P−C) − RISE) clocks per cycle. Example: P=125, C=69, RISE=20 gives 92 clocks.
- R4: Channel A rises in the cycle the upward counter shows C+RISE+1. It falls in the cycle the downward counter shows C−1.
- R5: Channel B is high for max(0, 2·C − FALL) clocks per cycle. It rises in the cycle the downward counter shows C−1−FALL, and it falls in the cycle the upward counter shows C+1.
- R6: `pwm_a` and `pwm_b` are never high in the same cycle.
- R7: A raw high or low phase that is not longer than its channel's delay produces no pulse at all on that channel.
- R8: A compare of 0, or one above P, never matches, so the raw waveform keeps its level. A compare equal to P gives a zero-width pulse, and the raw waveform stays low.
- R9: A period, compare or delay value written while the counter is not at zero has no effect until the counter next passes through zero.
- R10: While `en` is low, the counter, the direction and both outputs hold their values.
- R11: Synchronous reset clears the counter to 0 and `dir_down` to 0, drives `pwm_a` low, and loads the programmed settings. After reset, B stays low until FALL enabled clocks have passed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| en | input | 1 | Advances the counter and delay logic when high |
| period_in | input | CNT_W | Turnaround value P of the counter |
| cmp_in | input | CNT_W | Compare value C |
| rise_dly | input | DLY_W | Clocks by which channel A's rise is held back |
| fall_dly | input | DLY_W | Clocks by which channel B's rise is held back |
| pwm_a | output | 1 | Main channel |
| pwm_b | output | 1 | Complementary channel |
| cnt | output | CNT_W | Current counter value |
| dir_down | output | 1 | 1 while the counter is falling |

## Verification
Two events can land on the same clock: the compare match and the counter turning around at its peak. When the compare equals the period, the switch-on action and the switch-off action fall on one edge. A table row sets C = P to force this case. It passes only if channel A stays low for the whole cycle and channel B stays high for all 2·P clocks. A separate directed test loads a new period partway through a sweep. The peak of that sweep must still equal the old period, and the following sweep must use the new one.

// File: rtl/pwm_updown_db.sv
`timescale 1ns/1ps
module pwm_updown_db #(
  parameter int CNT_W = 16,
  parameter int DLY_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             en,
  input  logic [CNT_W-1:0] period_in,
  input  logic [CNT_W-1:0] cmp_in,
  input  logic [DLY_W-1:0] rise_dly,
  input  logic [DLY_W-1:0] fall_dly,
  output logic             pwm_a,
  output logic             pwm_b,
  output logic [CNT_W-1:0] cnt,
  output logic             dir_down
);

  localparam logic [CNT_W-1:0] C_ONE = 1;
  localparam logic [DLY_W-1:0] D_ONE = 1;

  logic [CNT_W-1:0] cnt_q, prd_q, cmp_q;
  logic [DLY_W-1:0] red_q, fed_q, ca_q, cb_q;
  logic             down_q, raw_q;

  wire at_zero = (cnt_q == '0);
  wire at_peak = !at_zero && !down_q && (cnt_q >= prd_q);
  wire cmp_hit = !at_zero && (cmp_q != '0) && (cnt_q == cmp_q);
  wire set_raw = cmp_hit && !down_q && !at_peak;
  wire clr_raw = cmp_hit && (down_q || at_peak);

  always_ff @(posedge clk) begin
    if (rst || (en && at_zero)) begin
      prd_q <= period_in;
      cmp_q <= cmp_in;
      red_q <= rise_dly;
      fed_q <= fall_dly;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q  <= '0;
      down_q <= 1'b0;
    end else if (en) begin
      if (at_zero) begin
        down_q <= 1'b0;
        cnt_q  <= (period_in == '0) ? '0 : C_ONE;
      end else if (at_peak) begin
        down_q <= 1'b1;
        cnt_q  <= cnt_q - C_ONE;
      end else if (down_q) begin
        cnt_q  <= cnt_q - C_ONE;
      end else begin
        cnt_q  <= cnt_q + C_ONE;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      raw_q <= 1'b0;
      ca_q  <= '0;
      cb_q  <= '0;
    end else if (en) begin
      if (set_raw)      raw_q <= 1'b1;
      else if (clr_raw) raw_q <= 1'b0;
      if (!raw_q)             ca_q <= '0;
      else if (ca_q < red_q)  ca_q <= ca_q + D_ONE;
      if (raw_q)              cb_q <= '0;
      else if (cb_q < fed_q)  cb_q <= cb_q + D_ONE;
    end
  end

  assign pwm_a    = raw_q && (ca_q >= red_q);
  assign pwm_b    = !raw_q && (cb_q >= fed_q);
  assign cnt      = cnt_q;
  assign dir_down = down_q;

  AST_NO_OVERLAP: assert property (@(posedge clk) disable iff (rst) !(pwm_a && pwm_b)); // R6
  AST_CNT_BOUND: assert property (@(posedge clk) disable iff (rst) (cnt_q != '0) |-> (cnt_q <= prd_q)); // R1
  AST_PEAK_TURN: assert property (@(posedge clk) disable iff (rst) (en && !down_q && cnt_q != '0 && cnt_q == prd_q) |=> down_q); // R2
  AST_ZERO_TURN: assert property (@(posedge clk) disable iff (rst) (en && cnt_q == '0) |=> !down_q); // R2
  AST_HOLD_CNT: assert property (@(posedge clk) disable iff (rst) !en |=> ($stable(cnt_q) && $stable(pwm_a) && $stable(pwm_b))); // R10
  AST_SHADOW: assert property (@(posedge clk) disable iff (rst) (cnt_q != '0) |=> ($stable(prd_q) && $stable(cmp_q))); // R9

endmodule

// File: tb/pwm_updown_db_test.sv
`timescale 1ns/1ps
module pwm_updown_db_test;
  logic clk = 1'b0, rst = 1'b1, en = 1'b0;
  logic [15:0] prd = 16'd10, cmpv = 16'd5;
  logic [7:0]  red = 8'd3, fed = 8'd2;
  wire pwm_a, pwm_b, dir_down;
  wire [15:0] cnt;
  int tests = 0, fails = 0;
  bit done = 0;

  always #2 clk = ~clk;

  pwm_updown_db uut (.clk(clk), .rst(rst), .en(en), .period_in(prd), .cmp_in(cmpv),
    .rise_dly(red), .fall_dly(fed), .pwm_a(pwm_a), .pwm_b(pwm_b), .cnt(cnt), .dir_down(dir_down));

  // {P, C, RISE, FALL, A high clocks, B high clocks}
  localparam int VEC [10][6] = '{
    '{125, 69, 20, 20, 92, 118},
    '{10, 5, 0, 0, 10, 10},
    '{10, 5, 3, 2, 7, 8},
    '{8, 7, 2, 1, 0, 13},
    '{8, 8, 1, 1, 0, 16},
    '{20, 1, 5, 0, 33, 2},
    '{20, 19, 0, 4, 2, 34},
    '{6, 3, 7, 7, 0, 0},
    '{10, 0, 0, 0, 0, 20},
    '{10, 11, 2, 0, 0, 20}
  };

  task automatic check(input bit ok, input string req, input int act, input int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic step();
    @(negedge clk);
  endtask

  task automatic wait_zero();
    int g = 0;
    step();
    while (cnt != 0 && g < 4000) begin step(); g++; end
  endtask

  task automatic measure(output int na, output int nb, output int len, output int maxc, output int ovl);
    na = 0; nb = 0; len = 0; maxc = 0; ovl = 0;
    do begin
      na += int'(pwm_a); nb += int'(pwm_b); ovl += int'(pwm_a && pwm_b);
      if (int'(cnt) > maxc) maxc = int'(cnt);
      len++;
      step();
    end while (cnt != 0 && len < 4000);
  endtask

  task automatic until_sig(input int which, input bit lvl);
    int g = 0;
    while (((which == 0) ? pwm_a : pwm_b) != lvl && g < 4000) begin step(); g++; end
  endtask

  initial begin
    int na, nb, len, maxc, ovl, c0;
    bit a0, b0;
    repeat (3) step();
    rst = 1'b0;
    check(cnt == 0, "R11 cnt after reset", int'(cnt), 0);
    check(dir_down == 0, "R11 dir after reset", int'(dir_down), 0);
    check(pwm_a == 0, "R11 pwm_a after reset", int'(pwm_a), 0);
    check(pwm_b == 0, "R11 pwm_b held by fall delay", int'(pwm_b), 0);
    en = 1'b1;

    foreach (VEC[i]) begin
      prd = 16'(VEC[i][0]); cmpv = 16'(VEC[i][1]);
      red = 8'(VEC[i][2]); fed = 8'(VEC[i][3]);
      wait_zero(); wait_zero(); wait_zero();
      measure(na, nb, len, maxc, ovl);
      check(na == VEC[i][4], $sformatf("R3/R7/R8 A high clocks row %0d", i), na, VEC[i][4]);
      check(nb == VEC[i][5], $sformatf("R5/R7/R8 B high clocks row %0d", i), nb, VEC[i][5]);
      check(len == 2 * VEC[i][0], $sformatf("R1 cycle length row %0d", i), len, 2 * VEC[i][0]);
      check(maxc == VEC[i][0], $sformatf("R1 peak row %0d", i), maxc, VEC[i][0]);
      check(ovl == 0, $sformatf("R6 overlap row %0d", i), ovl, 0);
    end

    // R4 / R5 edge placement
    prd = 16'd125; cmpv = 16'd69; red = 8'd20; fed = 8'd20;
    wait_zero(); wait_zero(); wait_zero();
    until_sig(0, 1'b1);
    check(cnt == 90 && !dir_down, "R4 A rise count", int'(cnt), 90);
    until_sig(0, 1'b0);
    check(cnt == 68 && dir_down, "R4 A fall count", int'(cnt), 68);
    until_sig(1, 1'b1);
    check(cnt == 48 && dir_down, "R5 B rise count", int'(cnt), 48);
    until_sig(1, 1'b0);
    check(cnt == 70 && !dir_down, "R5 B fall count", int'(cnt), 70);

    // R2 direction turnarounds
    prd = 16'd10; cmpv = 16'd5; red = 8'd3; fed = 8'd2;
    wait_zero(); wait_zero();
    while (cnt != 10) step();
    check(dir_down == 0, "R2 dir at peak", int'(dir_down), 0);
    step();
    check(cnt == 9 && dir_down == 1, "R2 dir after peak", int'(dir_down), 1);
    while (cnt != 0) step();
    check(dir_down == 1, "R2 dir arriving at zero", int'(dir_down), 1);
    step();
    check(cnt == 1 && dir_down == 0, "R2 dir after zero", int'(dir_down), 0);

    // R9 settings change mid-sweep
    while (cnt != 3) step();
    prd = 16'd20;
    maxc = 0;
    while (cnt != 0) begin if (int'(cnt) > maxc) maxc = int'(cnt); step(); end
    check(maxc == 10, "R9 old period kept", maxc, 10);
    measure(na, nb, len, maxc, ovl);
    check(maxc == 20 && len == 40, "R9 new period applied", maxc, 20);

    // R10 enable hold
    while (cnt != 7) step();
    c0 = int'(cnt); a0 = pwm_a; b0 = pwm_b;
    en = 1'b0;
    repeat (5) step();
    check(int'(cnt) == c0, "R10 cnt frozen", int'(cnt), c0);
    check(pwm_a == a0 && pwm_b == b0, "R10 outputs frozen", int'({pwm_a, pwm_b}), int'({a0, b0}));
    en = 1'b1;
    step();
    check(int'(cnt) != c0, "R10 resumes", int'(cnt), c0 + 1);

    // R11 reset mid-run
    rst = 1'b1;
    step();
    check(cnt == 0 && dir_down == 0 && pwm_a == 0, "R11 mid-run reset", int'(cnt), 0);
    rst = 1'b0;

    done = 1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    #800000;
    if (!done) begin
      tests++; fails++;
      $display("FAIL watchdog expired actual=hung expected=finish");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end
endmodule